// File: doc/BRIEF.md
# Weighted Deficit Round-Robin Link Scheduler

This block holds packet descriptors for an output link in a set of per-queue FIFOs and decides, one descriptor at a time, which queue sends next. Each descriptor carries a buffer pointer, a byte length and a copy count. The packet data itself is stored elsewhere. On arrival, a descriptor is checked against the identifier rules, the queue's byte limit and the FIFO's depth. It is either stored or discarded. A discard is announced by a single-cycle pulse that carries the identifier exactly as it was presented.

Service follows weighted deficit round-robin. A three-state machine walks the non-empty queues in circular order:

- **ST_IDLE** searches for the next non-empty queue, starting at the round-robin pointer. When it finds one, it takes the transition *found* to ST_CHARGE.
- **ST_CHARGE** adds that queue's quantum to the queue's deficit. It always takes the transition *charged* to ST_SERVE.
- **ST_SERVE** sends head descriptors while each one fits within the deficit, staying in ST_SERVE through the transition *sent*. When the queue has run empty it takes *drained*: the deficit is cleared and the machine returns to ST_IDLE. When the head no longer fits it takes *short*: the deficit is kept and the machine returns to ST_IDLE. Both of these transitions advance the pointer past the queue.

Software sets each queue's quantum and threshold through a single-word write port. A larger quantum gives a queue a proportionally larger share of link bytes.

Top module: `drr_link_sched`

## Requirements
- R1: After reset, `deq_valid` and `drop_valid` are low until a descriptor is sent or discarded.
- R2: An identifier's low 7 bits L select queue L-1 (0-based) when 1 ≤ L ≤ NUM_Q, and bit 7 is ignored, so 129 and 1 name the same queue. `deq_qid` always reports L, with bit 7 zero.
- R3: An enqueue whose identifier has L = 0 (this includes 0 and 128) or L > NUM_Q is discarded.
- R4: A descriptor is accepted only if the queue's stored bytes plus its length are no greater than the queue's threshold. An exact fit is accepted.
- R5: An enqueue to a queue that already holds FIFO_DEPTH descriptors is discarded.
- R6: Every discard raises `drop_valid` for exactly the one cycle after the enqueue, with `drop_qid` equal to the presented identifier.
- R7: Descriptors leave each queue in arrival order with pointer, length and copy count unchanged, and every accepted descriptor leaves exactly once.
- R8: Each visit adds the quantum to the queue's deficit. The head is sent only if its length is no greater than the deficit, and the length is then subtracted. A queue whose quantum is 0 never sends a descriptor of non-zero length.
- R9: A queue found empty in ST_SERVE has its deficit cleared, so leftover credit does not carry into its next busy period.
- R10: With all queues continuously backlogged, the number of equal-length descriptors each queue sends per round is ordered by its quantum.
- R11: A write with `cfg_we` high sets the quantum (`cfg_field` = 0) or the threshold (`cfg_field` = 1) of queue `cfg_qidx`, which is 0-based.
- R12: `deq_valid` is high for exactly one cycle per departing descriptor, and at most one descriptor departs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_qid | input | QID_W | Queue identifier of arrival |
| enq_len | input | LEN_W | Packet length in bytes |
| enq_ptr | input | PTR_W | Packet buffer pointer |
| enq_copies | input | CPY_W | Copy count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 1 | 0 = quantum, 1 = threshold |
| cfg_qidx | input | IDX_W | 0-based queue index written |
| cfg_value | input | CFG_W | Value written |
| deq_valid | output | 1 | Descriptor departs this cycle |
| deq_qid | output | QID_W | Identifier of the departing queue |
| deq_ptr | output | PTR_W | Departing pointer |
| deq_len | output | LEN_W | Departing length |
| deq_copies | output | CPY_W | Departing copy count |
| drop_valid | output | 1 | Arrival discarded (one-cycle pulse) |
| drop_qid | output | QID_W | Identifier of the discarded arrival |

## Verification
Directed arrivals separate the three discard causes from one another:

- Bad identifiers, which include the two aliases of zero.
- A byte sum that lands exactly on the threshold and then one byte over it.
- A FIFO filled to depth.

All of these are applied while every quantum is zero, so no departure can blur the occupancy. A single queue with a quantum smaller than its packets shows two things through departure latency: credit builds up over several visits, and credit is cleared when the queue drains. Three backlogged queues with different quanta show whether the share per round follows weight. A seeded random mix of identifiers, lengths and gaps then checks that per-queue order and descriptor contents are kept under interleaved arrival and service.

// File: rtl/drr_pkg.sv
package drr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_SERVE  = 2'd2
    } drr_state_e;

    localparam logic CFG_SEL_QUANTUM = 1'b0;
    localparam logic CFG_SEL_THRESH  = 1'b1;
endpackage

// File: rtl/drr_desc_fifo.sv
module drr_desc_fifo #(
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 11,
    parameter int PTR_W  = 16,
    parameter int CPY_W  = 4,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [PTR_W-1:0]  push_ptr,
    input  logic [CPY_W-1:0]  push_cpy,
    input  logic              pop,
    output logic              nonempty,
    output logic              full,
    output logic [LEN_W-1:0]  head_len,
    output logic [PTR_W-1:0]  head_ptr,
    output logic [CPY_W-1:0]  head_cpy,
    output logic [BYTE_W-1:0] bytes
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] ptr_mem [DEPTH];
    logic [CPY_W-1:0] cpy_mem [DEPTH];
    logic [AW-1:0]    wr_at, rd_at;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            len_mem[wr_at] <= push_len;
            ptr_mem[wr_at] <= push_ptr;
            cpy_mem[wr_at] <= push_cpy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_at <= '0;
            rd_at <= '0;
            count <= '0;
            bytes <= '0;
        end else begin
            if (push) wr_at <= (wr_at == AW'(DEPTH - 1)) ? '0 : wr_at + 1'b1;
            if (pop)  rd_at <= (rd_at == AW'(DEPTH - 1)) ? '0 : rd_at + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
            bytes <= bytes + (push ? BYTE_W'(push_len) : '0)
                           - (pop  ? BYTE_W'(head_len) : '0);
        end
    end

    assign nonempty = (count != '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign head_len = len_mem[rd_at];
    assign head_ptr = ptr_mem[rd_at];
    assign head_cpy = cpy_mem[rd_at];

    // R5: admission never writes into a full FIFO
    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the scheduler never takes from an empty FIFO
    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/drr_admit.sv
module drr_admit #(
    parameter int NQ     = 8,
    parameter int IDX_W  = 3,
    parameter int QID_W  = 8,
    parameter int LEN_W  = 11,
    parameter int BYTE_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [QID_W-1:0]             enq_qid,
    input  logic [LEN_W-1:0]             enq_len,
    input  logic [NQ-1:0]                full,
    input  logic [NQ-1:0][BYTE_W-1:0]    bytes,
    input  logic [NQ-1:0][CFG_W-1:0]     thresh,
    output logic [NQ-1:0]                push,
    output logic [IDX_W-1:0]             tgt_idx,
    output logic                         drop_valid,
    output logic [QID_W-1:0]             drop_qid
);
    localparam int LOW_W = QID_W - 1;
    localparam int SUM_W = ((BYTE_W > CFG_W) ? BYTE_W : CFG_W) + 1;
    localparam logic [LOW_W-1:0] MAX_LOW = LOW_W'(NQ);

    logic [LOW_W-1:0] low;
    logic             id_ok, room_ok, accept;
    logic [SUM_W-1:0] after_sum;

    always_comb begin
        low       = enq_qid[LOW_W-1:0];
        id_ok     = (low != '0) && (low <= MAX_LOW);
        tgt_idx   = IDX_W'(low - 1'b1);
        after_sum = SUM_W'(bytes[tgt_idx]) + SUM_W'(enq_len);
        room_ok   = !full[tgt_idx] && (after_sum <= SUM_W'(thresh[tgt_idx]));
        accept    = enq_valid && id_ok && room_ok;
        push      = '0;
        if (accept) push[tgt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_valid <= 1'b0;
            drop_qid   <= '0;
        end else begin
            drop_valid <= enq_valid && !accept;
            if (enq_valid) drop_qid <= enq_qid;
        end
    end

    // R3 / R6: a zero low field is always discarded and reported next cycle
    a_r3_zero_id_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_qid[LOW_W-1:0] == '0) |=> (drop_valid && drop_qid == $past(enq_qid)));
    // R6: a discard pulse always follows an arrival
    a_r6_drop_follows_enq: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> $past(enq_valid));
endmodule

// File: rtl/drr_cfg_regs.sv
module drr_cfg_regs #(
    parameter int NQ          = 8,
    parameter int IDX_W       = 3,
    parameter int CFG_W       = 16,
    parameter int DEF_QUANTUM = 1500,
    parameter int DEF_THRESH  = 8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_field,
    input  logic [IDX_W-1:0]         cfg_qidx,
    input  logic [CFG_W-1:0]         cfg_value,
    output logic [NQ-1:0][CFG_W-1:0] quantum,
    output logic [NQ-1:0][CFG_W-1:0] thresh
);
    import drr_pkg::*;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic hit;
        assign hit = cfg_we && (cfg_qidx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quantum[g] <= CFG_W'(DEF_QUANTUM);
                thresh[g]  <= CFG_W'(DEF_THRESH);
            end else if (hit) begin
                if (cfg_field == CFG_SEL_QUANTUM) quantum[g] <= cfg_value;
                else                              thresh[g]  <= cfg_value;
            end
        end
    end
endmodule

// File: rtl/drr_sched_fsm.sv
module drr_sched_fsm #(
    parameter int NQ    = 8,
    parameter int IDX_W = 3,
    parameter int LEN_W = 11,
    parameter int CFG_W = 16,
    parameter int DEF_W = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NQ-1:0]            nonempty,
    input  logic [NQ-1:0][LEN_W-1:0] head_len,
    input  logic [NQ-1:0][CFG_W-1:0] quantum,
    output logic                     pop_valid,
    output logic [IDX_W-1:0]         pop_idx
);
    import drr_pkg::*;

    drr_state_e             state, state_n;
    logic [IDX_W-1:0]       cur, cur_n, rr, rr_n, pick, after_cur;
    logic                   found, fits;
    logic [NQ-1:0][DEF_W-1:0] deficit;

    // circular search for the next non-empty queue, starting at rr
    always_comb begin
        found = 1'b0;
        pick  = rr;
        for (int k = NQ - 1; k >= 0; k--) begin
            int t;
            t = int'(rr) + k;
            if (t >= NQ) t = t - NQ;
            if (nonempty[IDX_W'(t)]) begin
                found = 1'b1;
                pick  = IDX_W'(t);
            end
        end
    end

    assign after_cur = (cur == IDX_W'(NQ - 1)) ? '0 : cur + 1'b1;
    assign fits      = DEF_W'(head_len[cur]) <= deficit[cur];

    always_comb begin
        state_n = state;
        cur_n   = cur;
        rr_n    = rr;
        unique case (state)
            ST_IDLE: begin
                if (found) begin
                    cur_n   = pick;
                    state_n = ST_CHARGE;
                end
            end
            ST_CHARGE: state_n = ST_SERVE;
            ST_SERVE: begin
                if (!nonempty[cur] || !fits) begin
                    rr_n    = after_cur;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            rr    <= '0;
        end else begin
            state <= state_n;
            cur   <= cur_n;
            rr    <= rr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deficit <= '0;
        end else begin
            unique case (state)
                ST_CHARGE: deficit[cur] <= deficit[cur] + DEF_W'(quantum[cur]);
                ST_SERVE: begin
                    if (!nonempty[cur])
                        deficit[cur] <= '0;
                    else if (fits)
                        deficit[cur] <= deficit[cur] - DEF_W'(head_len[cur]);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pop_valid = (state == ST_SERVE) && nonempty[cur] && fits;
        pop_idx   = cur;
    end

    // R9: credit is gone the cycle after a queue is found drained
    a_r9_drained_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && !nonempty[cur]) |=> (deficit[cur] == '0));
    // R8: each send pays exactly its length out of the deficit
    a_r8_send_pays: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> (deficit[cur] == $past(deficit[cur]) - DEF_W'($past(head_len[cur]))));
endmodule

// File: rtl/drr_link_sched.sv
module drr_link_sched #(
    parameter int NUM_Q       = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int QID_W       = 8,
    parameter int LEN_W       = 11,
    parameter int PTR_W       = 16,
    parameter int CPY_W       = 4,
    parameter int CFG_W       = 16,
    parameter int DEF_QUANTUM = 1500,
    parameter int DEF_THRESH  = 8000,
    localparam int IDX_W      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [QID_W-1:0] enq_qid,
    input  logic [LEN_W-1:0] enq_len,
    input  logic [PTR_W-1:0] enq_ptr,
    input  logic [CPY_W-1:0] enq_copies,
    input  logic             cfg_we,
    input  logic             cfg_field,
    input  logic [IDX_W-1:0] cfg_qidx,
    input  logic [CFG_W-1:0] cfg_value,
    output logic             deq_valid,
    output logic [QID_W-1:0] deq_qid,
    output logic [PTR_W-1:0] deq_ptr,
    output logic [LEN_W-1:0] deq_len,
    output logic [CPY_W-1:0] deq_copies,
    output logic             drop_valid,
    output logic [QID_W-1:0] drop_qid
);
    localparam int BYTE_W = LEN_W + $clog2(FIFO_DEPTH + 1);
    localparam int DEF_W  = ((CFG_W > LEN_W) ? CFG_W : LEN_W) + 1;

    logic [NUM_Q-1:0]              push_vec, pop_vec, full_vec, ne_vec;
    logic [NUM_Q-1:0][BYTE_W-1:0]  bytes_vec;
    logic [NUM_Q-1:0][LEN_W-1:0]   hlen;
    logic [NUM_Q-1:0][PTR_W-1:0]   hptr;
    logic [NUM_Q-1:0][CPY_W-1:0]   hcpy;
    logic [NUM_Q-1:0][CFG_W-1:0]   quantum, thresh;
    logic [IDX_W-1:0]              tgt_idx, pop_idx;
    logic                          pop_valid;

    drr_cfg_regs #(.NQ(NUM_Q), .IDX_W(IDX_W), .CFG_W(CFG_W),
                   .DEF_QUANTUM(DEF_QUANTUM), .DEF_THRESH(DEF_THRESH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_qidx(cfg_qidx), .cfg_value(cfg_value),
        .quantum(quantum), .thresh(thresh));

    drr_admit #(.NQ(NUM_Q), .IDX_W(IDX_W), .QID_W(QID_W), .LEN_W(LEN_W),
                .BYTE_W(BYTE_W), .CFG_W(CFG_W)) u_admit (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_qid(enq_qid),
        .enq_len(enq_len), .full(full_vec), .bytes(bytes_vec), .thresh(thresh),
        .push(push_vec), .tgt_idx(tgt_idx),
        .drop_valid(drop_valid), .drop_qid(drop_qid));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_fifo
        assign pop_vec[g] = pop_valid && (pop_idx == IDX_W'(g));
        drr_desc_fifo #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W),
                        .CPY_W(CPY_W), .BYTE_W(BYTE_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push_vec[g]), .push_len(enq_len), .push_ptr(enq_ptr),
            .push_cpy(enq_copies), .pop(pop_vec[g]),
            .nonempty(ne_vec[g]), .full(full_vec[g]),
            .head_len(hlen[g]), .head_ptr(hptr[g]), .head_cpy(hcpy[g]),
            .bytes(bytes_vec[g]));
    end

    drr_sched_fsm #(.NQ(NUM_Q), .IDX_W(IDX_W), .LEN_W(LEN_W), .CFG_W(CFG_W),
                    .DEF_W(DEF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .nonempty(ne_vec), .head_len(hlen),
        .quantum(quantum), .pop_valid(pop_valid), .pop_idx(pop_idx));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deq_valid  <= 1'b0;
            deq_qid    <= '0;
            deq_ptr    <= '0;
            deq_len    <= '0;
            deq_copies <= '0;
        end else begin
            deq_valid <= pop_valid;
            if (pop_valid) begin
                deq_qid    <= QID_W'(pop_idx) + QID_W'(1);
                deq_ptr    <= hptr[pop_idx];
                deq_len    <= hlen[pop_idx];
                deq_copies <= hcpy[pop_idx];
            end
        end
    end

    // R2: departures always report an in-range identifier with bit 7 clear
    a_r2_deq_id_range: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> (deq_qid != '0 && deq_qid <= QID_W'(NUM_Q)));
    // R4: an accepted arrival never leaves its queue above threshold
    a_r4_push_within_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (|push_vec) |=> (bytes_vec[$past(tgt_idx)] <= BYTE_W'(thresh[$past(tgt_idx)])
                         || $past(pop_vec[tgt_idx])));
endmodule

// File: tb/drr_link_sched_tb_top.sv
module drr_link_sched_tb_top;
    localparam int NQ = 8, LEN_W = 11, PTR_W = 16, CPY_W = 4, QID_W = 8;
    localparam int CFG_W = 16, IDX_W = 3, SB = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enq_valid = 1'b0, cfg_we = 1'b0, cfg_field = 1'b0;
    logic [QID_W-1:0] enq_qid = '0;
    logic [LEN_W-1:0] enq_len = '0;
    logic [PTR_W-1:0] enq_ptr = '0;
    logic [CPY_W-1:0] enq_copies = '0;
    logic [IDX_W-1:0] cfg_qidx = '0;
    logic [CFG_W-1:0] cfg_value = '0;
    logic deq_valid, drop_valid;
    logic [QID_W-1:0] deq_qid, drop_qid;
    logic [PTR_W-1:0] deq_ptr;
    logic [LEN_W-1:0] deq_len;
    logic [CPY_W-1:0] deq_copies;

    drr_link_sched dut_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_qid(enq_qid),
        .enq_len(enq_len), .enq_ptr(enq_ptr), .enq_copies(enq_copies),
        .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_qidx(cfg_qidx),
        .cfg_value(cfg_value), .deq_valid(deq_valid), .deq_qid(deq_qid),
        .deq_ptr(deq_ptr), .deq_len(deq_len), .deq_copies(deq_copies),
        .drop_valid(drop_valid), .drop_qid(drop_qid));

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, total_dep = 0;
    int sb_ptr [NQ][SB];
    int sb_len [NQ][SB];
    int sb_cpy [NQ][SB];
    int sb_hd [NQ];
    int sb_tl [NQ];
    int win_cnt [NQ];
    int win_n = 0;
    bit win_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    function automatic int qidx(input int qid);
        int low;
        low = qid % 128;
        if (low == 0 || low > NQ) return -1;
        return low - 1;
    endfunction

    function automatic int pending();
        int s;
        s = 0;
        for (int q = 0; q < NQ; q++) s += sb_tl[q] - sb_hd[q];
        return s;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // departure monitor: per-queue order and content (R7), id format (R2)
    always @(negedge clk) begin
        if (rst_n && deq_valid) begin
            int q, h;
            q = int'(deq_qid) - 1;
            if (q < 0 || q >= NQ) begin
                chk(1'b0, "R2 deq_qid range", int'(deq_qid), 1);
            end else if (sb_tl[q] == sb_hd[q]) begin
                chk(1'b0, "R7 unexpected departure", q, -1);
            end else begin
                h = sb_hd[q] % SB;
                chk(int'(deq_ptr) == sb_ptr[q][h] && int'(deq_len) == sb_len[q][h]
                    && int'(deq_copies) == sb_cpy[q][h],
                    "R7 descriptor order/content", int'(deq_ptr), sb_ptr[q][h]);
                sb_hd[q]++;
                total_dep++;
                if (win_on && win_n < 30) begin
                    win_cnt[q]++;
                    win_n++;
                end
            end
        end
    end

    task automatic enq(input int qid, input int len, output bit dropped);
        int q, p, c, t;
        p = int'($urandom_range(0, 65535));
        c = int'($urandom_range(1, 15));
        enq_valid  = 1'b1;
        enq_qid    = QID_W'(qid);
        enq_len    = LEN_W'(len);
        enq_ptr    = PTR_W'(p);
        enq_copies = CPY_W'(c);
        @(negedge clk);
        enq_valid = 1'b0;
        dropped = drop_valid;
        if (dropped) chk(int'(drop_qid) == qid, "R6 drop_qid", int'(drop_qid), qid);
        q = qidx(qid);
        if (!dropped && q >= 0) begin
            t = sb_tl[q] % SB;
            sb_ptr[q][t] = p;
            sb_len[q][t] = len;
            sb_cpy[q][t] = c;
            sb_tl[q]++;
        end
    endtask

    task automatic cfg(input bit field, input int idx, input int val);
        cfg_we    = 1'b1;
        cfg_field = field;
        cfg_qidx  = IDX_W'(idx);
        cfg_value = CFG_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (pending() == 0) break;
            @(negedge clk);
        end
        chk(pending() == 0, "R7 all accepted descriptors departed", pending(), 0);
    endtask

    initial begin
        bit d;
        int cnt, seed_v, dep0;
        seed_v = int'($urandom(32'd7411));
        for (int q = 0; q < NQ; q++) begin
            sb_hd[q] = 0; sb_tl[q] = 0; win_cnt[q] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!deq_valid && !drop_valid, "R1 idle outputs after reset",
            int'(deq_valid) + int'(drop_valid), 0);

        // quantum 0 everywhere so occupancy stays fixed (R11, R8)
        for (int q = 0; q < NQ; q++) begin
            cfg(1'b0, q, 0);
            cfg(1'b1, q, 60000);
        end

        // R3: reserved and out-of-range identifiers
        enq(0, 64, d);   chk(d, "R3 qid 0 discarded", d, 1);
        enq(128, 64, d); chk(d, "R3 qid 128 discarded", d, 1);
        chk(int'(drop_qid) == 128, "R6 drop carries 128", int'(drop_qid), 128);
        @(negedge clk);
        chk(!drop_valid, "R6 drop pulse lasts one cycle", drop_valid, 0);
        enq(9, 64, d);   chk(d, "R3 qid 9 out of range", d, 1);
        enq(137, 64, d); chk(d, "R3 qid 137 out of range", d, 1);

        // R2: alias with bit 7 set lands in queue 0
        enq(129, 40, d); chk(!d, "R2 qid 129 accepted", d, 0);

        // R5: fill queue index 2 to depth
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            enq(3, 10, d);
            if (!d) cnt++;
        end
        chk(cnt == 16, "R5 depth accepted", cnt, 16);
        enq(3, 10, d); chk(d, "R5 full FIFO discards", d, 1);

        // R4: threshold boundary on queue index 3
        cfg(1'b1, 3, 1000);
        enq(4, 600, d); chk(!d, "R4 under threshold", d, 0);
        enq(4, 400, d); chk(!d, "R4 exact threshold accepted", d, 0);
        enq(4, 1, d);   chk(d, "R4 one byte over discarded", d, 1);

        repeat (40) @(negedge clk);
        chk(total_dep == 0, "R8 zero quantum sends nothing", total_dep, 0);

        cfg(1'b0, 0, 2000);
        cfg(1'b0, 2, 2000);
        cfg(1'b0, 3, 2000);
        drain(400);
        chk(total_dep == 19, "R12 one pulse per descriptor", total_dep, 19);

        // R8: quantum 100, packet 250 needs three visits
        repeat (5) @(negedge clk);
        cfg(1'b0, 4, 100);
        enq(5, 250, d);
        cnt = 0;
        while (!deq_valid && cnt < 60) begin @(negedge clk); cnt++; end
        chk(cnt >= 8 && cnt <= 12, "R8 credit builds over visits", cnt, 9);
        // R9: leftover 50 must not carry into the next busy period
        repeat (6) @(negedge clk);
        enq(5, 150, d);
        cnt = 0;
        while (!deq_valid && cnt < 60) begin @(negedge clk); cnt++; end
        chk(cnt >= 5 && cnt <= 9, "R9 drained queue restarts from zero", cnt, 6);
        repeat (4) @(negedge clk);

        // R10: weighted share with quanta 500/1000/1500 on length-100 packets
        for (int i = 0; i < 16; i++) begin
            enq(6, 100, d); enq(7, 100, d); enq(8, 100, d);
        end
        win_on = 1'b1;
        cfg(1'b0, 5, 500);
        cfg(1'b0, 6, 1000);
        cfg(1'b0, 7, 1500);
        cnt = 0;
        while (win_n < 30 && cnt < 2000) begin @(negedge clk); cnt++; end
        win_on = 1'b0;
        chk(win_cnt[5] < win_cnt[6] && win_cnt[6] < win_cnt[7],
            "R10 share ordered by quantum", win_cnt[7], 15);
        drain(2000);

        // R11/R7 random mix
        for (int q = 0; q < NQ; q++) begin
            cfg(1'b0, q, int'($urandom_range(200, 1700)));
            cfg(1'b1, q, 3000);
        end
        dep0 = total_dep;
        for (int i = 0; i < 300; i++) begin
            int r, qid;
            r = int'($urandom_range(0, 19));
            if (r < 16) qid = (r % 8) + 1 + ((r >= 8) ? 128 : 0);
            else if (r == 16) qid = 0;
            else if (r == 17) qid = 128;
            else if (r == 18) qid = 9;
            else qid = 200;
            enq(qid, int'($urandom_range(1, 1500)), d);
            if (qidx(qid) < 0) chk(d, "R3 random bad id discarded", d, 1);
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
        end
        drain(20000);
        chk(total_dep > dep0, "R7 random traffic departed", total_dep - dep0, 1);
        summary();
    end
endmodule